// File: doc/BRIEF.md
# Bit-Programmable Pattern Match Detector

This block watches a narrow parallel input port and raises an interrupt when the port shows a pattern that software has described bit by bit. Each input bit can be left out of the match, or can be asked to hold a level, to show an edge in a given direction, or to change at all. A per-bit inversion register flips selected inputs before they are examined. The per-bit results are then merged in AND mode, where every participating bit must be satisfied at once, or in OR mode, where one satisfied bit is enough.

Software sets the block up through a small write port and reads it back through a registered read port. A command/status register holds the interrupt-enable, interrupt-pending and interrupt-under-service flags and a pattern-match flag. Commands in that register set or clear the flags one at a time. The interrupt line is high while an enabled interrupt is pending and not already under service.

Top module: `pmatch_port`

## Requirements
- R1: Each bit is described by the triple (mask, transition, polarity) at register addresses 0, 1 and 2. The encodings are: (0,0,x) the bit takes no part; (0,1,x) the bit is satisfied by any change; (1,0,p) the bit is satisfied while it equals p; (1,1,1) the bit is satisfied by a rise; (1,1,0) the bit is satisfied by a fall. An edge is judged between the previous sample and the current one.
- R2: An inversion bit set to 1 at address 3 flips the corresponding input before sampling, so levels and edge directions apply to the flipped value.
- R3: Bits 2:1 of the mode register at address 4 pick how the bits combine. Code 0 never matches. Code 1 (AND) matches when at least one bit takes part and every participating bit is satisfied. Codes 2 and 3 (OR) match when any participating bit is satisfied.
- R4: In AND mode, more than one bit with mask=1 and transition=1 is a configuration error. The error shows as status bit 4, and no match is produced while it lasts.
- R5: A match event sets interrupt-pending (status bit 5) and the pattern-match flag (status bit 1) only while interrupt-enable (status bit 6) is set. Interrupt-pending then stays set until a clear command. An input change sampled at one clock edge sets the flags at the next edge.
- R6: With mode bit 3 (match-only) set, a match event is a rise of the match condition. With it clear, a match event is any change of the match condition, up or down.
- R7: A write to the status register at address 5 carries a command in bits 7:5: 0 none, 1 clear pending and under-service, 2 set under-service, 3 clear under-service, 4 set pending, 5 clear pending, 6 set enable, 7 clear enable. Both pending-clear commands also clear the pattern-match flag. Bit 0 of every status write is kept as a stored bit.
- R8: `irq_o` equals enable AND pending AND NOT under-service, aligned with the flags' own clock edge.
- R9: A match event in the same cycle as a pending-clear command leaves interrupt-pending set.
- R10: Every register reads back one cycle after its read address is presented. The mode register returns all eight bits as written. The status register reads as {under-service, enable, pending, error, 2'b00, match flag, stored bit 0}.
- R11: After reset all registers read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | W | Port input data |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every per-bit encoding against all four previous/current bit pairs under every combine mode. A wrong edge direction or a swapped level would show here as a missing or extra interrupt. Random multi-bit vectors with random inversion catch a combine that treats an empty AND as satisfied, and an inversion applied after edge detection. The same vectors catch an AND check that lets two edge bits through without flagging an error. Directed sequences cover three further faults: a clear command that beats a same-cycle match and loses the event, an under-service flag that fails to hold the line low, and a match-only bit whose sense is inverted so that falling matches raise the line.

// File: rtl/pmatch_pkg.sv
package pmatch_pkg;
  typedef enum logic [2:0] {
    RA_MASK  = 3'd0,
    RA_TRANS = 3'd1,
    RA_POL   = 3'd2,
    RA_INV   = 3'd3,
    RA_MODE  = 3'd4,
    RA_STAT  = 3'd5
  } reg_addr_e;

  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_CLR_IP_IUS = 3'd1,
    CMD_SET_IUS    = 3'd2,
    CMD_CLR_IUS    = 3'd3,
    CMD_SET_IP     = 3'd4,
    CMD_CLR_IP     = 3'd5,
    CMD_SET_IE     = 3'd6,
    CMD_CLR_IE     = 3'd7
  } st_cmd_e;

  typedef enum logic [1:0] {
    MM_OFF    = 2'd0,
    MM_AND    = 2'd1,
    MM_OR     = 2'd2,
    MM_OR_PRI = 2'd3
  } match_mode_e;

  localparam int MODE_MM_LSB = 1;
  localparam int MODE_IMO    = 3;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 3;
endpackage

// File: rtl/pmatch_cfg.sv
module pmatch_cfg
  import pmatch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      trans_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      inv_q,
  output logic [REG_W-1:0]  mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      trans_q <= '0;
      pol_q   <= '0;
      inv_q   <= '0;
      mode_q  <= '0;
    end else if (we) begin
      case (addr)
        RA_MASK:  mask_q  <= wdata[W-1:0];
        RA_TRANS: trans_q <= wdata[W-1:0];
        RA_POL:   pol_q   <= wdata[W-1:0];
        RA_INV:   inv_q   <= wdata[W-1:0];
        RA_MODE:  mode_q  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pmatch_cell.sv
module pmatch_cell (
  input  logic m,
  input  logic t,
  input  logic p,
  input  logic cur,
  input  logic prev,
  output logic part,
  output logic edge_cfg,
  output logic hit
);
  logic changed;
  assign changed = cur ^ prev;

  always_comb begin
    part     = m | t;
    edge_cfg = m & t;
    case ({m, t})
      2'b00:   hit = 1'b0;
      2'b01:   hit = changed;
      2'b10:   hit = (cur == p);
      default: hit = changed & (cur == p);
    endcase
  end
endmodule

// File: rtl/pmatch_eval.sv
module pmatch_eval
  import pmatch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] inv,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] trans,
  input  logic [W-1:0] pol,
  input  logic [1:0]   mm,
  output logic         match,
  output logic         err
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] d_cur, d_prev;
  logic [W-1:0] part, edge_cfg, hit;
  logic [CW-1:0] n_edge;
  logic any_part, any_hit, all_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_cur  <= '0;
      d_prev <= '0;
    end else begin
      d_cur  <= pin ^ inv;
      d_prev <= d_cur;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_cell
    pmatch_cell u_cell (
      .m       (mask[i]),
      .t       (trans[i]),
      .p       (pol[i]),
      .cur     (d_cur[i]),
      .prev    (d_prev[i]),
      .part    (part[i]),
      .edge_cfg(edge_cfg[i]),
      .hit     (hit[i])
    );
  end

  always_comb begin
    n_edge = '0;
    for (int i = 0; i < W; i++) n_edge = n_edge + CW'(edge_cfg[i]);
  end

  assign any_part = |part;
  assign any_hit  = |(hit & part);
  assign all_hit  = &(hit | ~part);

  always_comb begin
    err = (match_mode_e'(mm) == MM_AND) && (n_edge > CW'(1));
    case (match_mode_e'(mm))
      MM_AND:           match = any_part & all_hit & ~err;
      MM_OR, MM_OR_PRI: match = any_hit;
      default:          match = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmatch_flags.sv
module pmatch_flags
  import pmatch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       match,
  input  logic       imo,
  input  logic       st_we,
  input  logic [2:0] st_cmd,
  input  logic       st_bit0,
  output logic       ie_q,
  output logic       ip_q,
  output logic       ius_q,
  output logic       pmf_q,
  output logic       ioe_q,
  output logic       irq_q,
  output logic       match_last
);
  logic ev;
  logic ie_n, ip_n, ius_n, pmf_n, ioe_n;

  assign ev = imo ? (match & ~match_last) : (match ^ match_last);

  always_comb begin
    ie_n  = ie_q;
    ip_n  = ip_q;
    ius_n = ius_q;
    pmf_n = pmf_q;
    ioe_n = ioe_q;
    if (st_we) begin
      ioe_n = st_bit0;
      case (st_cmd_e'(st_cmd))
        CMD_CLR_IP_IUS: begin ip_n = 1'b0; ius_n = 1'b0; pmf_n = 1'b0; end
        CMD_SET_IUS:    ius_n = 1'b1;
        CMD_CLR_IUS:    ius_n = 1'b0;
        CMD_SET_IP:     ip_n  = 1'b1;
        CMD_CLR_IP:     begin ip_n = 1'b0; pmf_n = 1'b0; end
        CMD_SET_IE:     ie_n  = 1'b1;
        CMD_CLR_IE:     ie_n  = 1'b0;
        default: ;
      endcase
    end
    // a detected event outranks a same-cycle clear
    if (ev && ie_q) begin
      ip_n  = 1'b1;
      pmf_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q       <= 1'b0;
      ip_q       <= 1'b0;
      ius_q      <= 1'b0;
      pmf_q      <= 1'b0;
      ioe_q      <= 1'b0;
      irq_q      <= 1'b0;
      match_last <= 1'b0;
    end else begin
      ie_q       <= ie_n;
      ip_q       <= ip_n;
      ius_q      <= ius_n;
      pmf_q      <= pmf_n;
      ioe_q      <= ioe_n;
      irq_q      <= ie_n & ip_n & ~ius_n;
      match_last <= match;
    end
  end
endmodule

// File: rtl/pmatch_port.sv
module pmatch_port
  import pmatch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [W-1:0]     mask_q, trans_q, pol_q, inv_q;
  logic [REG_W-1:0] mode_q;
  logic             match_now, match_last, cfg_err;
  logic             st_ie, st_ip, st_ius, st_pmf, st_ioe;
  logic             st_we;
  logic [REG_W-1:0] rd_mux;

  assign st_we = wr_en_i && (wr_addr_i == RA_STAT);

  pmatch_cfg #(.W(W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en_i),
    .addr   (wr_addr_i),
    .wdata  (wr_data_i),
    .mask_q (mask_q),
    .trans_q(trans_q),
    .pol_q  (pol_q),
    .inv_q  (inv_q),
    .mode_q (mode_q)
  );

  pmatch_eval #(.W(W)) u_eval (
    .clk  (clk),
    .rst  (rst),
    .pin  (pin_i),
    .inv  (inv_q),
    .mask (mask_q),
    .trans(trans_q),
    .pol  (pol_q),
    .mm   (mode_q[MODE_MM_LSB+1:MODE_MM_LSB]),
    .match(match_now),
    .err  (cfg_err)
  );

  pmatch_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .match     (match_now),
    .imo       (mode_q[MODE_IMO]),
    .st_we     (st_we),
    .st_cmd    (wr_data_i[7:5]),
    .st_bit0   (wr_data_i[0]),
    .ie_q      (st_ie),
    .ip_q      (st_ip),
    .ius_q     (st_ius),
    .pmf_q     (st_pmf),
    .ioe_q     (st_ioe),
    .irq_q     (irq_o),
    .match_last(match_last)
  );

  always_comb begin
    rd_mux = '0;
    case (rd_addr_i)
      RA_MASK:  rd_mux[W-1:0] = mask_q;
      RA_TRANS: rd_mux[W-1:0] = trans_q;
      RA_POL:   rd_mux[W-1:0] = pol_q;
      RA_INV:   rd_mux[W-1:0] = inv_q;
      RA_MODE:  rd_mux = mode_q;
      RA_STAT:  rd_mux = {st_ius, st_ie, st_ip, cfg_err, 2'b00, st_pmf, st_ioe};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end
endmodule

// File: rtl/pmatch_port_chk.sv
module pmatch_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       st_we,
  input logic [2:0] st_cmd,
  input logic       irq_o,
  input logic       ie,
  input logic       ip,
  input logic       ius,
  input logic       match_now,
  input logic       match_last,
  input logic       cfg_err,
  input logic [1:0] mm
);
  // R8: the line is only up with enable, pending and no service in progress
  a_r8_irq_flags: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ie && ip && !ius));

  // R5: pending rises only through an enabled event or the set command
  a_r5_ip_source: assert property (@(posedge clk) disable iff (rst)
    $rose(ip) |-> ($past(ie) || $past(st_we && st_cmd == 3'd4)));

  // R5: pending drops only through a clear command
  a_r5_ip_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(ip) |-> $past(st_we && (st_cmd == 3'd1 || st_cmd == 3'd5)));

  // R6: an event-driven rise of pending needs a change of the match condition
  a_r6_event_change: assert property (@(posedge clk) disable iff (rst)
    ($rose(ip) && !$past(st_we && st_cmd == 3'd4)) |-> $past(match_now != match_last));

  // R4: a bad AND configuration yields no match
  a_r4_err_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !match_now);

  // R3: mode code 0 never matches
  a_r3_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mm == 2'd0) |-> !match_now);
endmodule

bind pmatch_port pmatch_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .st_we     (st_we),
  .st_cmd    (wr_data_i[7:5]),
  .irq_o     (irq_o),
  .ie        (st_ie),
  .ip        (st_ip),
  .ius       (st_ius),
  .match_now (match_now),
  .match_last(match_last),
  .cfg_err   (cfg_err),
  .mm        (mode_q[2:1])
);

// File: tb/pmatch_port_bench.sv
module pmatch_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pin_i = '0;
  logic         wr_en_i = 1'b0;
  logic [2:0]   wr_addr_i = '0;
  logic [7:0]   wr_data_i = '0;
  logic [2:0]   rd_addr_i = '0;
  logic [7:0]   rdata_o;
  logic         irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  pmatch_port #(.W(W)) u_pmatch_port (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr_i = a;
    @(negedge clk);
    d = rdata_o;
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // match condition from the encodings in R1..R4
  function automatic logic ref_match(input logic [W-1:0] m, t, p, inv,
                                     input logic [1:0] mode,
                                     input logic [W-1:0] prev_raw, cur_raw);
    logic [W-1:0] c, q;
    logic part, any, all, h;
    int ne;
    c = cur_raw ^ inv; q = prev_raw ^ inv;
    part = 0; any = 0; all = 1; ne = 0;
    for (int i = 0; i < W; i++) begin
      if (m[i] || t[i]) begin
        part = 1;
        if (!t[i])     h = (c[i] == p[i]);
        else if (m[i]) h = (c[i] != q[i]) && (c[i] == p[i]);
        else           h = (c[i] != q[i]);
        any |= h; all &= h;
        if (m[i] && t[i]) ne++;
      end
    end
    case (mode)
      2'd1:    return part && all && (ne <= 1);
      2'd2,
      2'd3:    return any;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_err(input logic [W-1:0] m, t, input logic [1:0] mode);
    return (mode == 2'd1) && ($countones(m & t) > 1);
  endfunction

  // configure, settle on prev, clear pending, step to cur, check the line
  task automatic run_vec(input string tag, input logic [W-1:0] m, t, p, inv,
                         input logic [1:0] mode, input logic [W-1:0] prev, cur);
    logic [7:0] st;
    logic exp;
    wr(3'd0, m); wr(3'd1, t); wr(3'd2, p); wr(3'd3, inv);
    wr(3'd4, 8'h08 | {5'd0, mode, 1'b0});
    wr(3'd5, 8'hC0);
    pin_i = prev;
    repeat (3) @(negedge clk);
    rd(3'd5, st);
    check({tag, " R4 err flag"}, {7'd0, st[4]}, {7'd0, ref_err(m, t, mode)});
    wr(3'd5, 8'h20);
    pin_i = cur;
    @(posedge clk); @(posedge clk); @(negedge clk);
    exp = ref_match(m, t, p, inv, mode, prev, cur) && !ref_match(m, t, p, inv, mode, prev, prev);
    check(tag, {7'd0, irq_o}, {7'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 irq after reset", {7'd0, irq_o}, 8'd0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R11 register after reset", v, 8'h00);
    end

    // R10 readback
    wr(3'd4, 8'hDB); rd(3'd4, v); check("R10 mode readback", v, 8'hDB);
    wr(3'd0, 8'hA5); rd(3'd0, v); check("R10 mask readback", v, 8'hA5);

    // R1 / R3 exhaustive single-bit sweep over encodings, bit pairs and modes
    for (int mode = 0; mode < 4; mode++)
      for (int code = 0; code < 6; code++)
        for (int pc = 0; pc < 4; pc++) begin
          logic mb, tb, pb;
          logic [W-1:0] pv, cv;
          int b;
          b = (code + mode) % W;
          case (code)
            0: {mb, tb, pb} = 3'b000;
            1: {mb, tb, pb} = 3'b010;
            2: {mb, tb, pb} = 3'b100;
            3: {mb, tb, pb} = 3'b101;
            4: {mb, tb, pb} = 3'b110;
            default: {mb, tb, pb} = 3'b111;
          endcase
          lfsr = step(lfsr);
          pv = lfsr[W-1:0]; cv = lfsr[W+7:8];
          pv[b] = pc[1]; cv[b] = pc[0];
          run_vec("R1 R3 single-bit sweep", W'(mb) << b, W'(tb) << b, W'(pb) << b,
                  '0, 2'(mode), pv, cv);
        end

    // R2 directed: inverted bit0 low reads as high level
    run_vec("R2 inversion level", 8'h01, 8'h00, 8'h01, 8'h01, 2'd2, 8'h01, 8'h00);
    // R4 directed: two edge bits in AND mode
    run_vec("R4 two edges in AND", 8'h03, 8'h03, 8'h03, 8'h00, 2'd1, 8'h00, 8'h03);

    // R2 R3 R4 random multi-bit vectors
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] m, t, p, iv, pv, cv;
      lfsr = step(lfsr); m = lfsr[7:0]; t = lfsr[15:8] & lfsr[23:16]; p = lfsr[31:24];
      lfsr = step(lfsr); iv = lfsr[7:0]; pv = lfsr[15:8];
      cv = pv ^ (lfsr[23:16] & lfsr[31:24]);
      run_vec("R2 R3 R4 random", m, t, p, iv, 2'(k % 4), pv, cv);
    end

    // R9: event in the same cycle as a clear leaves pending set
    wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h01); wr(3'd3, 8'h00);
    wr(3'd4, 8'h0C); wr(3'd5, 8'hC0);
    pin_i = 8'h00; repeat (3) @(negedge clk);
    wr(3'd5, 8'h20);
    pin_i = 8'h01;
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 8'h20;
    @(negedge clk);
    wr_en_i = 1'b0;
    check("R9 set beats clear", {7'd0, irq_o}, 8'd1);

    // R5 hold after the match goes away
    pin_i = 8'h00; repeat (5) @(negedge clk);
    check("R5 pending held", {7'd0, irq_o}, 8'd1);
    rd(3'd5, v); check("R5 status with match flag", v, 8'h62);
    wr(3'd5, 8'h20);
    check("R7 clear pending", {7'd0, irq_o}, 8'd0);

    // R7 / R8 commands
    wr(3'd5, 8'h80); check("R7 set pending", {7'd0, irq_o}, 8'd1);
    wr(3'd5, 8'h40); check("R8 under service blocks", {7'd0, irq_o}, 8'd0);
    rd(3'd5, v);     check("R7 status after set ius", v, 8'hE0);
    wr(3'd5, 8'h60); check("R8 clear ius restores", {7'd0, irq_o}, 8'd1);
    wr(3'd5, 8'hA0); check("R7 clear pending only", {7'd0, irq_o}, 8'd0);
    wr(3'd5, 8'hE0); wr(3'd5, 8'h80);
    check("R8 no enable no line", {7'd0, irq_o}, 8'd0);
    rd(3'd5, v);     check("R7 pending without enable", v, 8'h20);
    wr(3'd5, 8'h21); rd(3'd5, v); check("R7 bit0 kept", v, 8'h01);
    wr(3'd5, 8'h00); rd(3'd5, v); check("R7 bit0 rewritten", v, 8'h00);

    // R5 enable gating: event with enable clear leaves nothing
    pin_i = 8'h00; repeat (3) @(negedge clk);
    pin_i = 8'h01; repeat (3) @(negedge clk);
    check("R5 gated by enable", {7'd0, irq_o}, 8'd0);
    rd(3'd5, v); check("R5 status untouched", v, 8'h00);

    // R6: match-only clear, falling match is an event
    wr(3'd4, 8'h04); wr(3'd5, 8'hC0);
    pin_i = 8'h01; repeat (3) @(negedge clk);
    wr(3'd5, 8'h20);
    pin_i = 8'h00; @(posedge clk); @(posedge clk); @(negedge clk);
    check("R6 fall counts without match-only", {7'd0, irq_o}, 8'd1);
    wr(3'd4, 8'h0C);
    pin_i = 8'h01; repeat (3) @(negedge clk);
    wr(3'd5, 8'h20);
    pin_i = 8'h00; @(posedge clk); @(posedge clk); @(negedge clk);
    check("R6 fall ignored with match-only", {7'd0, irq_o}, 8'd0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule